// File: doc/BRIEF.md
# Screen memory strobe sequencer with processor clock stalling

This block sits between a 16 KB screen memory built from DRAM with multiplexed addresses and the two agents that use it. A video fetch unit reads the memory in page-mode bursts: one row strobe and two column strobes, which fetch two bytes from the same row. A processor reads and writes single bytes, one normal row-then-column cycle at a time. The block is the only master of the memory. It generates the row and column strobes, the write enable, the 7-bit multiplexed address and the row/column select.

While the display fetch window is open, the processor is never allowed onto the memory. If the processor asks for the memory, or for one of the controller's I/O ports, inside that window, its clock enable is pulled low before any memory cycle of its own starts. The clock enable returns only when the window closes. The first byte of every display burst is loaded into an 8-bit pixel shift register, which moves one pixel per pixel-clock enable. The second byte is held on an auxiliary output.

Fetch requests use a valid/ready handshake. `fch_ready` is high only when the sequencer is idle and the display window is open. A request is accepted on a clock edge where both `fch_valid` and `fch_ready` are high. The requester must hold `fch_valid` and its row and column fields stable until that edge. The processor holds `cpu_req` and its fields until it sees `cpu_ack`.

Top module: `vram_ctrl`

## Requirements
- R1: After reset, `ram_ras_n`, `ram_cas_n` and `ram_we_n` are 1, `mux_sel` is 0, `cpu_clk_en` is 1, `cpu_ack` is 0 and `pix_out` is 0.
- R2: A processor write stores `cpu_wdata` at the memory cell whose row is `cpu_addr[13:7]` and whose column is `cpu_addr[6:0]`. It completes with a one-cycle `cpu_ack`.
- R3: A processor read returns, on `cpu_rdata` while `cpu_ack` is high, the byte the memory drove while CAS was low. That byte is captured before CAS rises.
- R4: RAS falls while `mux_sel` is 0 and the row is on `ram_a`. `mux_sel` is 1 for at least one cycle before CAS falls. CAS is low only while RAS is low.
- R5: An accepted display fetch produces exactly one RAS fall and two CAS falls: column `fch_col0` first, then `fch_col1`, both in row `fch_row`. `ram_we_n` stays 1 throughout.
- R6: After a burst, the first byte is in the pixel shift register. `pix_out` shows bit 7 first and advances one bit per `pix_en` cycle. Zeros follow the eighth pixel.
- R7: After a burst, `fch_aux` holds the second byte fetched.
- R8: While the display window is open, a pending processor request starts no memory cycle. Display fetches run in its place, and the processor's cycle runs after the window closes.
- R9: `cpu_clk_en` is 0 whenever a display burst is in progress, or when `cpu_req` or `cpu_io` is high while `disp_win` is high. It is 1 otherwise.
- R10: While `disp_win` is 0, `fch_ready` is 0 and a high `fch_valid` starts no RAS cycle.
- R11: While `disp_win` is 0, a processor request runs with `cpu_clk_en` held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_win | input | 1 | Display fetch window is open (low during border and flyback) |
| fch_valid | input | 1 | Display fetch request valid |
| fch_ready | output | 1 | Fetch request can be accepted |
| fch_row | input | 7 | Row of the fetch burst |
| fch_col0 | input | 7 | Column of the first (pixel) byte |
| fch_col1 | input | 7 | Column of the second byte |
| pix_en | input | 1 | Pixel clock enable, shifts the pixel register |
| pix_out | output | 1 | Current pixel |
| fch_aux | output | 8 | Second byte of the last burst |
| cpu_req | input | 1 | Processor memory request |
| cpu_io | input | 1 | Processor access to a controller I/O port |
| cpu_we | input | 1 | Processor request is a write |
| cpu_addr | input | 14 | Processor byte address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data, valid with cpu_ack |
| cpu_ack | output | 1 | Processor cycle finished |
| cpu_clk_en | output | 1 | Processor clock enable |
| ram_a | output | 7 | Multiplexed memory address |
| ram_ras_n | output | 1 | Row strobe, active low |
| ram_cas_n | output | 1 | Column strobe, active low |
| mux_sel | output | 1 | 0 selects row, 1 selects column |
| ram_we_n | output | 1 | Write enable, active low |
| ram_dout | output | 8 | Data to memory |
| ram_din | input | 8 | Data from memory |

## Verification
The bench's memory model drives a marker byte whenever CAS is high. A sequencer that captured data after CAS rose would therefore return that marker instead of the stored byte. Writes go to the two ends of the address space and to addresses that differ only in their row half or only in their column half. A design that swapped or mis-split the row and column bits would then read back the wrong values. The bench holds a processor write pending while a page burst runs, and counts every cycle in which the processor clock enable was high during that burst. A design that let the processor slip in would corrupt the write count or raise that counter. Fetch requests raised during the border must not produce a single RAS fall.

// File: rtl/vram_pkg.sv
package vram_pkg;
  typedef enum logic [2:0] {
    V_IDLE,
    V_ROW,
    V_MUX,
    V_COL,
    V_PAGE,
    V_REL
  } vst_e;
endpackage

// File: rtl/vram_seq.sv
module vram_seq
  import vram_pkg::*;
#(
  parameter int AW        = 7,
  parameter int DW        = 8,
  parameter int ROW_TICKS = 1,
  parameter int CAS_TICKS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_disp,
  input  logic            start_cpu,
  input  logic [AW-1:0]   d_row,
  input  logic [AW-1:0]   d_col0,
  input  logic [AW-1:0]   d_col1,
  input  logic [2*AW-1:0] c_addr,
  input  logic            c_we,
  input  logic [DW-1:0]   c_wdata,
  input  logic [DW-1:0]   ram_din,
  output logic [AW-1:0]   ram_a,
  output logic            ram_ras_n,
  output logic            ram_cas_n,
  output logic            mux_sel,
  output logic            ram_we_n,
  output logic [DW-1:0]   ram_dout,
  output logic            busy,
  output logic            disp_active,
  output logic            fin_disp,
  output logic            fin_cpu,
  output logic [DW-1:0]   byte0,
  output logic [DW-1:0]   byte1
);
  localparam int TMAX = (ROW_TICKS > CAS_TICKS) ? ROW_TICKS : CAS_TICKS;
  localparam int CW   = $clog2(TMAX + 1);

  vst_e          st;
  logic [CW-1:0] cnt;
  logic          second, is_disp, wr;
  logic [AW-1:0] row_q, c0_q, c1_q;
  logic [DW-1:0] wd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= V_IDLE;
      cnt     <= '0;
      second  <= 1'b0;
      is_disp <= 1'b0;
      wr      <= 1'b0;
      row_q   <= '0;
      c0_q    <= '0;
      c1_q    <= '0;
      wd_q    <= '0;
      byte0   <= '0;
      byte1   <= '0;
    end else begin
      case (st)
        V_IDLE: begin
          cnt    <= '0;
          second <= 1'b0;
          if (start_disp) begin
            row_q   <= d_row;
            c0_q    <= d_col0;
            c1_q    <= d_col1;
            is_disp <= 1'b1;
            wr      <= 1'b0;
            st      <= V_ROW;
          end else if (start_cpu) begin
            row_q   <= c_addr[2*AW-1:AW];
            c0_q    <= c_addr[AW-1:0];
            c1_q    <= c_addr[AW-1:0];
            is_disp <= 1'b0;
            wr      <= c_we;
            wd_q    <= c_wdata;
            st      <= V_ROW;
          end
        end
        V_ROW: begin
          if (cnt == CW'(ROW_TICKS - 1)) begin
            cnt <= '0;
            st  <= V_MUX;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        V_MUX: begin
          cnt <= '0;
          st  <= V_COL;
        end
        V_COL: begin
          if (cnt == CW'(CAS_TICKS - 1)) begin
            cnt <= '0;
            if (second) byte1 <= ram_din;
            else        byte0 <= ram_din;
            if (is_disp && !second) begin
              second <= 1'b1;
              st     <= V_PAGE;
            end else begin
              st <= V_REL;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        V_PAGE: st <= V_COL;
        V_REL: begin
          second <= 1'b0;
          st     <= V_IDLE;
        end
        default: st <= V_IDLE;
      endcase
    end
  end

  always_comb begin
    ram_ras_n   = (st == V_IDLE) || (st == V_REL);
    ram_cas_n   = (st != V_COL);
    mux_sel     = (st == V_MUX) || (st == V_COL) || (st == V_PAGE);
    ram_a       = mux_sel ? (second ? c1_q : c0_q) : row_q;
    ram_we_n    = !(wr && !is_disp && ((st == V_MUX) || (st == V_COL)));
    ram_dout    = wd_q;
    busy        = (st != V_IDLE);
    disp_active = is_disp && busy;
    fin_disp    = (st == V_REL) && is_disp;
    fin_cpu     = (st == V_REL) && !is_disp;
  end

  // R4
  ras_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_ras_n) |-> !mux_sel);
  // R4
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cas_n |-> !ram_ras_n);
  // R4
  col_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_cas_n) |-> ($past(mux_sel) && mux_sel));
  // R5
  disp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_active |-> ram_we_n);
  // R5
  page_ras_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == V_PAGE) |-> (!ram_ras_n && $stable(ram_ras_n)));
endmodule

// File: rtl/vram_shift.sv
module vram_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          step,
  output logic          pix
);
  logic [DW-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
    else if (step) q <= {q[DW-2:0], 1'b0};
  end

  assign pix = q[DW-1];

  // R6
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step) |=> (pix == $past(q[DW-2])));
endmodule

// File: rtl/vram_ctrl.sv
module vram_ctrl #(
  parameter int AW        = 7,
  parameter int DW        = 8,
  parameter int ROW_TICKS = 1,
  parameter int CAS_TICKS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            disp_win,
  input  logic            fch_valid,
  output logic            fch_ready,
  input  logic [AW-1:0]   fch_row,
  input  logic [AW-1:0]   fch_col0,
  input  logic [AW-1:0]   fch_col1,
  input  logic            pix_en,
  output logic            pix_out,
  output logic [DW-1:0]   fch_aux,
  input  logic            cpu_req,
  input  logic            cpu_io,
  input  logic            cpu_we,
  input  logic [2*AW-1:0] cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  output logic [DW-1:0]   cpu_rdata,
  output logic            cpu_ack,
  output logic            cpu_clk_en,
  output logic [AW-1:0]   ram_a,
  output logic            ram_ras_n,
  output logic            ram_cas_n,
  output logic            mux_sel,
  output logic            ram_we_n,
  output logic [DW-1:0]   ram_dout,
  input  logic [DW-1:0]   ram_din
);
  logic          busy, disp_active, fin_disp, fin_cpu;
  logic          start_disp, start_cpu;
  logic [DW-1:0] byte0, byte1;

  assign fch_ready  = !busy && disp_win;
  assign start_disp = fch_valid && fch_ready;
  assign start_cpu  = !busy && cpu_req && !disp_win;
  assign cpu_clk_en = !(disp_active || ((cpu_req || cpu_io) && disp_win));
  assign cpu_ack    = fin_cpu;
  assign cpu_rdata  = byte0;
  assign fch_aux    = byte1;

  vram_seq #(
    .AW(AW), .DW(DW), .ROW_TICKS(ROW_TICKS), .CAS_TICKS(CAS_TICKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_disp(start_disp), .start_cpu(start_cpu),
    .d_row(fch_row), .d_col0(fch_col0), .d_col1(fch_col1),
    .c_addr(cpu_addr), .c_we(cpu_we), .c_wdata(cpu_wdata),
    .ram_din(ram_din), .ram_a(ram_a), .ram_ras_n(ram_ras_n),
    .ram_cas_n(ram_cas_n), .mux_sel(mux_sel), .ram_we_n(ram_we_n),
    .ram_dout(ram_dout), .busy(busy), .disp_active(disp_active),
    .fin_disp(fin_disp), .fin_cpu(fin_cpu), .byte0(byte0), .byte1(byte1)
  );

  vram_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(fin_disp), .din(byte0),
    .step(pix_en), .pix(pix_out)
  );

  // R9
  burst_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_active |-> !cpu_clk_en);
  // R10
  border_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !disp_win) |=> !disp_active);
  // R8
  win_nocpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && disp_win) |=> (!busy || disp_active));
endmodule

// File: tb/sim_vram_ctrl.sv
module sim_vram_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_win = 1'b0, fch_valid = 1'b0, pix_en = 1'b0;
  logic [6:0]  fch_row = '0, fch_col0 = '0, fch_col1 = '0;
  logic        cpu_req = 1'b0, cpu_io = 1'b0, cpu_we = 1'b0;
  logic [13:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        fch_ready, pix_out, cpu_ack, cpu_clk_en;
  logic [7:0]  fch_aux, cpu_rdata, ram_dout, ram_din;
  logic [6:0]  ram_a;
  logic        ram_ras_n, ram_cas_n, mux_sel, ram_we_n;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  vram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .disp_win(disp_win), .fch_valid(fch_valid),
    .fch_ready(fch_ready), .fch_row(fch_row), .fch_col0(fch_col0),
    .fch_col1(fch_col1), .pix_en(pix_en), .pix_out(pix_out),
    .fch_aux(fch_aux), .cpu_req(cpu_req), .cpu_io(cpu_io), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ack(cpu_ack), .cpu_clk_en(cpu_clk_en), .ram_a(ram_a),
    .ram_ras_n(ram_ras_n), .ram_cas_n(ram_cas_n), .mux_sel(mux_sel),
    .ram_we_n(ram_we_n), .ram_dout(ram_dout), .ram_din(ram_din)
  );

  // memory model: row on RAS fall, column on CAS fall, marker byte while CAS is high
  logic [7:0]  mem [int];
  logic [6:0]  m_row = '0, m_col = '0, first_col = '0;
  logic [7:0]  rdv = '0;
  logic        pr = 1'b1, pc = 1'b1, in_burst = 1'b0;
  int          ras_falls = 0, cas_falls = 0, writes = 0, hold_bad = 0, we_in_burst = 0;

  assign ram_din = ram_cas_n ? 8'h5A : rdv;

  always @(negedge clk) begin
    if (pr && !ram_ras_n) begin
      m_row = ram_a;
      ras_falls++;
    end
    if (pc && !ram_cas_n) begin
      first_col = m_col;
      m_col = ram_a;
      cas_falls++;
      if (!ram_we_n) begin
        mem[int'({m_row, m_col})] = ram_dout;
        writes++;
      end
    end
    rdv = mem.exists(int'({m_row, m_col})) ? mem[int'({m_row, m_col})] : 8'h00;
    if (in_burst && cpu_clk_en) hold_bad++;
    if (in_burst && !ram_we_n) we_in_burst++;
    pr = ram_ras_n;
    pc = ram_cas_n;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_cycle(input bit we, input [13:0] a, input [7:0] d, output [7:0] rd);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    rd = 8'hFF;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (cpu_ack) begin
        rd = cpu_rdata;
        break;
      end
    end
    cpu_req = 1'b0;
  endtask

  task automatic fetch(input [6:0] r, input [6:0] c0, input [6:0] c1);
    @(negedge clk);
    fch_valid = 1'b1; fch_row = r; fch_col0 = c0; fch_col1 = c1;
    for (int i = 0; i < 200; i++) begin
      if (fch_ready) break;
      @(negedge clk);
    end
    in_burst = 1'b1;
    @(negedge clk);
    fch_valid = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (ram_ras_n) break;
      @(negedge clk);
    end
    in_burst = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // write table: {address, data}
  localparam logic [21:0] VEC [5] = '{
    {14'h0000, 8'h11}, {14'h3FFF, 8'hEE}, {14'h0080, 8'hB4},
    {14'h0085, 8'h3C}, {14'h0001, 8'h77}
  };

  initial begin
    logic [7:0] rd;
    int r0, c0, w0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ram_ras_n && ram_cas_n && ram_we_n && !mux_sel, "R1 strobes", {ram_ras_n, ram_cas_n, ram_we_n, mux_sel}, 4'b1110);
    chk(cpu_clk_en && !cpu_ack && !pix_out, "R1 cpu/pix", {cpu_clk_en, cpu_ack, pix_out}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R11 writes during border
    for (int i = 0; i < 5; i++) begin
      w0 = writes;
      cpu_cycle(1'b1, VEC[i][21:8], VEC[i][7:0], rd);
      chk(writes == w0 + 1, "R2 write count", writes - w0, 1);
      chk(mem.exists(int'(VEC[i][21:8])) && mem[int'(VEC[i][21:8])] == VEC[i][7:0],
          "R2 stored", mem.exists(int'(VEC[i][21:8])) ? mem[int'(VEC[i][21:8])] : 'hFFF, VEC[i][7:0]);
    end
    // R3 read back
    for (int i = 0; i < 5; i++) begin
      cpu_cycle(1'b0, VEC[i][21:8], 8'h00, rd);
      chk(rd == VEC[i][7:0], "R3 read", rd, VEC[i][7:0]);
    end
    // R11 no stall during border
    @(negedge clk); cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 14'h0001;
    @(negedge clk);
    chk(cpu_clk_en == 1'b1, "R11 clk_en in border", cpu_clk_en, 1);
    for (int i = 0; i < 50 && !cpu_ack; i++) @(negedge clk);
    cpu_req = 1'b0;

    // R10 fetch ignored in border
    r0 = ras_falls;
    fch_valid = 1'b1; fch_row = 7'h01;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (fch_ready) chk(1'b0, "R10 ready in border", fch_ready, 0);
    end
    fch_valid = 1'b0;
    chk(ras_falls == r0, "R10 no RAS", ras_falls - r0, 0);

    // R9 I/O stall
    disp_win = 1'b1; cpu_io = 1'b1;
    @(negedge clk);
    chk(cpu_clk_en == 1'b0, "R9 io stall", cpu_clk_en, 0);
    disp_win = 1'b0;
    @(negedge clk);
    chk(cpu_clk_en == 1'b1, "R9 io released", cpu_clk_en, 1);
    cpu_io = 1'b0;

    // R8 / R9 / R5: pending write held off while a burst runs
    disp_win = 1'b1;
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 14'h0002; cpu_wdata = 8'h99;
    @(negedge clk);
    chk(cpu_clk_en == 1'b0, "R9 req stall", cpu_clk_en, 0);
    r0 = ras_falls; c0 = cas_falls; w0 = writes;
    fetch(7'h01, 7'h00, 7'h05);
    chk(ras_falls - r0 == 1, "R5 one RAS", ras_falls - r0, 1);
    chk(cas_falls - c0 == 2, "R5 two CAS", cas_falls - c0, 2);
    chk(first_col == 7'h00 && m_col == 7'h05 && m_row == 7'h01, "R5 columns",
        {m_row, first_col, m_col}, {7'h01, 7'h00, 7'h05});
    chk(we_in_burst == 0, "R5 no write", we_in_burst, 0);
    chk(hold_bad == 0, "R9 clk during burst", hold_bad, 0);
    chk(writes == w0, "R8 cpu held", writes - w0, 0);
    chk(fch_aux == 8'h3C, "R7 aux", fch_aux, 8'h3C);
    // R6 pixel order
    for (int i = 7; i >= 0; i--) begin
      chk(pix_out == 1'(8'hB4 >> i), "R6 pixel", pix_out, 1'(8'hB4 >> i));
      pix_en = 1'b1; @(negedge clk); pix_en = 1'b0;
    end
    chk(pix_out == 1'b0, "R6 zero fill", pix_out, 0);
    // R8 cpu runs after window closes
    disp_win = 1'b0;
    for (int i = 0; i < 50 && !cpu_ack; i++) @(negedge clk);
    cpu_req = 1'b0;
    chk(writes == w0 + 1, "R8 cpu after window", writes - w0, 1);
    cpu_cycle(1'b0, 14'h0002, 8'h00, rd);
    chk(rd == 8'h99, "R8 readback", rd, 8'h99);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule